// File: doc/BRIEF.md
# Packet-Framed DMA Transfer Engine

This block sits between an external DMA controller and one endpoint packet buffer. The controller sees a request/acknowledge handshake: the engine raises a request line, the controller answers with an active-low acknowledge, and moves one byte per active-low read or write strobe on an 8-bit bus. An active-low end-of-transfer input lets the controller finish early. On the buffer side the engine drives a byte address, write enable and write data, and reads the byte at the addressed location. It pulses a commit strobe when a packet it built is complete and a release strobe when it has emptied a packet.

Packets in the buffer are framed. Offset 0 is a reserved byte that holds 00h, offset 1 holds the payload length, and the payload starts at offset 2. The DMA side only ever carries payload bytes. In the write direction (memory to buffer) the engine counts the bytes, ends the packet at `MAX_PKT` bytes or on end-of-transfer, and then writes the two header bytes itself. In the read direction (buffer to memory) it fetches the length from offset 1 and streams out that many payload bytes. A one-byte configuration register selects the burst length, enable, direction and auto-restart. An end-of-transfer flag is raised for software and is cleared by a read strobe.

Top module: `dmaf_engine`

## Requirements
- R1: After reset, `dmreq` is 0, `cfg_q` reads 00h, `eot_irq` is 0 and no buffer write, commit or release strobe is active.
- R2: A `cfg_wr` pulse loads `cfg_wdata`. The field layout is: bits [1:0] burst select, bit 2 enable, bit 3 direction (1 = write into buffer, 0 = read from buffer), bit 4 auto-restart. Bits 7..5 always read back as 0.
- R3: `dmreq` is high only while the block is enabled, a packet is in progress and the buffer is ready (`buf_free` for writes, `buf_full` for reads). A strobe or end-of-transfer given while `dmack_n` is high has no effect.
- R4: Burst select 00/01/10/11 gives bursts of 1/4/8/16 strobes. `dmreq` drops in the same cycle as the final strobe of a burst goes low, stays low until that strobe has returned high, and then rises again.
- R5: In the write direction, the n-th payload byte of a packet (n from 0) is written at buffer offset 2+n on the falling edge of `wr_n`.
- R6: When the write count reaches `MAX_PKT`, the engine writes 00h at offset 0, then writes the length at offset 1 together with a one-cycle `buf_commit` pulse.
- R7: End-of-transfer in the write direction closes the packet early and commits it with the byte count gathered so far, including a byte whose strobe falls in the same cycle. With zero bytes gathered, nothing is written or committed.
- R8: In the read direction the engine takes the length from offset 1 and presents the byte at offset 2+n on `dma_rdata`. It pulses `buf_release` after the last payload byte. A zero-length packet is released without any request.
- R9: `dmreq` is low in any cycle in which `eot_n` and `dmack_n` are both low. When auto-restart is 0, end-of-transfer clears the enable bit.
- R10: With auto-restart set, end-of-transfer leaves the enable bit set, and the engine requests again as soon as the buffer is ready.
- R11: End-of-transfer sets `eot_irq`, and an `eot_rd` pulse clears it. If both happen in the same cycle, the set wins.
- R12: End-of-transfer in the read direction releases the current packet, even if not all of its payload was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte to load |
| cfg_q | output | 8 | Configuration register contents |
| eot_rd | input | 1 | Read strobe for the end-of-transfer flag (clears it) |
| eot_irq | output | 1 | End-of-transfer flag |
| dmreq | output | 1 | DMA request to the controller |
| dmack_n | input | 1 | DMA acknowledge, active low |
| eot_n | input | 1 | End of transfer, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| dma_wdata | input | 8 | Byte from memory |
| dma_rdata | output | 8 | Byte to memory |
| buf_addr | output | AW = clog2(MAX_PKT+2) | Buffer byte offset |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Byte at `buf_addr` |
| buf_free | input | 1 | Buffer can take a new packet |
| buf_full | input | 1 | Buffer holds a packet to read |
| buf_commit | output | 1 | Packet written and framed |
| buf_release | output | 1 | Packet consumed |

## Verification
A wrong byte count shows at the ports one or two cycles after the packet closes: the length byte at offset 1 is wrong, or the commit or release fires at the wrong strobe. A stuck burst counter or hold flag shows within one strobe: `dmreq` stays high through a final strobe, or stays low after the strobe has returned high. A bad end-of-transfer path shows on the next clock: the enable bit is still set, the flag is missing, or the final byte is left out of the committed length. The bench checks each of these at the cycle in which it must first appear.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN,
        ST_MOVE,
        ST_HDR0,
        ST_HDR1
    } st_e;

    localparam int          CFG_EN   = 2;
    localparam int          CFG_DIR  = 3;
    localparam int          CFG_AUTO = 4;
    localparam logic [7:0]  CFG_MASK = 8'h1F;

    typedef struct packed {
        logic [7:0] cfg;
        logic       irq;
    } cfg_st_t;

    function automatic logic [3:0] burst_lim(input logic [1:0] sel);
        case (sel)
            2'b00:   burst_lim = 4'd0;
            2'b01:   burst_lim = 4'd3;
            2'b10:   burst_lim = 4'd7;
            default: burst_lim = 4'd15;
        endcase
    endfunction

endpackage

// File: rtl/dmaf_cfg.sv
module dmaf_cfg
    import dmaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    input  logic       eot_done,
    input  logic       eot_rd,
    output logic [7:0] cfg_q,
    output logic       eot_irq
);
    cfg_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (eot_done && !s_q.cfg[CFG_AUTO])
            s_d.cfg[CFG_EN] = 1'b0;
        if (cfg_wr)
            s_d.cfg = cfg_wdata & CFG_MASK;
        if (eot_rd)
            s_d.irq = 1'b0;
        if (eot_done)
            s_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_q   = s_q.cfg;
    assign eot_irq = s_q.irq;
endmodule

// File: rtl/dmaf_sampler.sv
module dmaf_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    input  logic dmack_n,
    input  logic rd_n,
    input  logic wr_n,
    input  logic eot_n,
    output logic strb_low,
    output logic strb_edge,
    output logic eot_low,
    output logic eot_hit
);
    typedef struct packed {
        logic rd;
        logic wr;
        logic eot;
    } prev_t;

    prev_t p_d, p_q;

    always_comb begin
        p_d.rd  = rd_n;
        p_d.wr  = wr_n;
        p_d.eot = eot_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '1;
        else        p_q <= p_d;
    end

    logic sel_n, sel_prev;
    assign sel_n    = dir ? wr_n : rd_n;
    assign sel_prev = dir ? p_q.wr : p_q.rd;

    assign strb_low  = !dmack_n && !sel_n;
    assign strb_edge = strb_low && sel_prev;
    assign eot_low   = !dmack_n && !eot_n;
    assign eot_hit   = eot_low && p_q.eot;
endmodule

// File: rtl/dmaf_beat.sv
module dmaf_beat
    import dmaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [1:0] sel,
    output logic       last
);
    logic [3:0] cnt_d, cnt_q;

    assign last = (cnt_q == burst_lim(sel));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (step) cnt_d = last ? 4'd0 : cnt_q + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dmaf_fsm.sv
module dmaf_fsm
    import dmaf_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int AW      = $clog2(MAX_PKT + 2),
    parameter int CW      = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          dir,
    input  logic          buf_free,
    input  logic          buf_full,
    input  logic [7:0]    buf_rdata,
    input  logic [7:0]    dma_wdata,
    input  logic          strb_low,
    input  logic          strb_edge,
    input  logic          eot_low,
    input  logic          eot_hit,
    input  logic          beat_last,
    output logic          beat_clr,
    output logic          beat_step,
    output logic          eot_done,
    output logic          dmreq,
    output logic [AW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    output logic          buf_commit,
    output logic          buf_release
);
    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
        logic          hold;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [CW-1:0] cnt_nx;
    logic          pkt_last;
    logic          last_beat;
    logic [CW-1:0] len_in;
    logic          ready;

    assign cnt_nx    = f_q.cnt + 1'b1;
    assign pkt_last  = dir ? (cnt_nx == CW'(MAX_PKT)) : (cnt_nx == f_q.len);
    assign last_beat = beat_last || pkt_last;
    assign len_in    = (buf_rdata > 8'(MAX_PKT)) ? CW'(MAX_PKT) : buf_rdata[CW-1:0];
    assign ready     = dir ? buf_free : 1'b1;

    always_comb begin
        f_d         = f_q;
        beat_clr    = 1'b0;
        beat_step   = 1'b0;
        eot_done    = 1'b0;
        buf_addr    = '0;
        buf_we      = 1'b0;
        buf_wdata   = dma_wdata;
        buf_commit  = 1'b0;
        buf_release = 1'b0;

        case (f_q.st)
            ST_IDLE: begin
                f_d.hold = 1'b0;
                if (en && dir && buf_free) begin
                    f_d.st   = ST_MOVE;
                    f_d.cnt  = '0;
                    beat_clr = 1'b1;
                end else if (en && !dir && buf_full) begin
                    f_d.st = ST_LEN;
                end
            end

            ST_LEN: begin
                buf_addr = AW'(1);
                if (len_in == '0) begin
                    buf_release = 1'b1;
                    f_d.st      = ST_IDLE;
                end else begin
                    f_d.len  = len_in;
                    f_d.cnt  = '0;
                    f_d.st   = ST_MOVE;
                    beat_clr = 1'b1;
                end
            end

            ST_MOVE: begin
                buf_addr = AW'(f_q.cnt) + AW'(2);
                if (!en) begin
                    f_d.st = ST_IDLE;
                end else begin
                    if (f_q.hold && !strb_low)
                        f_d.hold = 1'b0;
                    if (strb_edge) begin
                        beat_step = 1'b1;
                        f_d.cnt   = cnt_nx;
                        buf_we    = dir;
                        if (last_beat)
                            f_d.hold = 1'b1;
                    end
                    eot_done = eot_hit;
                    if (dir) begin
                        if ((strb_edge && pkt_last) ||
                            (eot_hit && (strb_edge || f_q.cnt != '0)))
                            f_d.st = ST_HDR0;
                        else if (eot_hit)
                            f_d.st = ST_IDLE;
                    end else if ((strb_edge && pkt_last) || eot_hit) begin
                        buf_release = 1'b1;
                        f_d.st      = ST_IDLE;
                    end
                end
            end

            ST_HDR0: begin
                buf_addr  = '0;
                buf_we    = 1'b1;
                buf_wdata = 8'h00;
                f_d.st    = ST_HDR1;
            end

            ST_HDR1: begin
                buf_addr   = AW'(1);
                buf_we     = 1'b1;
                buf_wdata  = 8'(f_q.cnt);
                buf_commit = 1'b1;
                f_d.st     = ST_IDLE;
            end

            default: f_d.st = ST_IDLE;
        endcase
    end

    assign dmreq = (f_q.st == ST_MOVE) && en && ready && !f_q.hold &&
                   !(strb_low && last_beat) && !eot_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st   <= ST_IDLE;
            f_q.cnt  <= '0;
            f_q.len  <= '0;
            f_q.hold <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end
endmodule

// File: rtl/dmaf_engine.sv
module dmaf_engine
    import dmaf_pkg::*;
#(
    parameter int MAX_PKT = 64,
    localparam int AW     = $clog2(MAX_PKT + 2),
    localparam int CW     = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_q,
    input  logic          eot_rd,
    output logic          eot_irq,
    output logic          dmreq,
    input  logic          dmack_n,
    input  logic          eot_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [7:0]    dma_wdata,
    output logic [7:0]    dma_rdata,
    output logic [AW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    input  logic [7:0]    buf_rdata,
    input  logic          buf_free,
    input  logic          buf_full,
    output logic          buf_commit,
    output logic          buf_release
);
    logic strb_low, strb_edge, eot_low, eot_hit;
    logic beat_clr, beat_step, beat_last, eot_done;

    dmaf_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .eot_done (eot_done),
        .eot_rd   (eot_rd),
        .cfg_q    (cfg_q),
        .eot_irq  (eot_irq)
    );

    dmaf_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (cfg_q[CFG_DIR]),
        .dmack_n  (dmack_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .eot_n    (eot_n),
        .strb_low (strb_low),
        .strb_edge(strb_edge),
        .eot_low  (eot_low),
        .eot_hit  (eot_hit)
    );

    dmaf_beat u_beat (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (beat_clr),
        .step (beat_step),
        .sel  (cfg_q[1:0]),
        .last (beat_last)
    );

    dmaf_fsm #(.MAX_PKT(MAX_PKT), .AW(AW), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_q[CFG_EN]),
        .dir        (cfg_q[CFG_DIR]),
        .buf_free   (buf_free),
        .buf_full   (buf_full),
        .buf_rdata  (buf_rdata),
        .dma_wdata  (dma_wdata),
        .strb_low   (strb_low),
        .strb_edge  (strb_edge),
        .eot_low    (eot_low),
        .eot_hit    (eot_hit),
        .beat_last  (beat_last),
        .beat_clr   (beat_clr),
        .beat_step  (beat_step),
        .eot_done   (eot_done),
        .dmreq      (dmreq),
        .buf_addr   (buf_addr),
        .buf_we     (buf_we),
        .buf_wdata  (buf_wdata),
        .buf_commit (buf_commit),
        .buf_release(buf_release)
    );

    assign dma_rdata = buf_rdata;
endmodule

// File: rtl/dmaf_checker.sv
module dmaf_checker #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dmreq,
    input logic          dmack_n,
    input logic          eot_n,
    input logic          cfg_wr,
    input logic [7:0]    cfg_q,
    input logic          eot_irq,
    input logic [AW-1:0] buf_addr,
    input logic          buf_we,
    input logic [7:0]    buf_wdata,
    input logic          buf_commit,
    input logic          buf_release
);
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dmreq |-> cfg_q[2]); // R3

    AST_EOT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!dmack_n && !eot_n) |-> !dmreq); // R9

    AST_WE_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> cfg_q[3]); // R5

    AST_REL_READ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        buf_release |-> !cfg_q[3]); // R8

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        buf_commit |=> !buf_commit); // R6

    AST_HDR_BEFORE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_commit |-> $past(buf_we && buf_addr == '0 && buf_wdata == 8'h00)); // R6

    AST_COMMIT_LEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        buf_commit |-> (buf_we && buf_addr == AW'(1))); // R6

    AST_FLAG_FROM_EOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eot_irq) |-> (!$past(eot_n) && !$past(dmack_n))); // R11

    AST_EN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(eot_irq) && !cfg_q[4] && !$past(cfg_wr)) |-> !cfg_q[2]); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7:5] == 3'b000); // R2
endmodule

bind dmaf_engine dmaf_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dmreq      (dmreq),
    .dmack_n    (dmack_n),
    .eot_n      (eot_n),
    .cfg_wr     (cfg_wr),
    .cfg_q      (cfg_q),
    .eot_irq    (eot_irq),
    .buf_addr   (buf_addr),
    .buf_we     (buf_we),
    .buf_wdata  (buf_wdata),
    .buf_commit (buf_commit),
    .buf_release(buf_release)
);

// File: tb/sim_dmaf_engine.sv
module sim_dmaf_engine;
    localparam int MAX = 8;
    localparam int AW  = $clog2(MAX + 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_q;
    logic          eot_rd = 1'b0;
    logic          eot_irq;
    logic          dmreq;
    logic          dmack_n = 1'b1;
    logic          eot_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [7:0]    dma_wdata = '0;
    logic [7:0]    dma_rdata;
    logic [AW-1:0] buf_addr;
    logic          buf_we;
    logic [7:0]    buf_wdata;
    logic [7:0]    buf_rdata;
    logic          buf_free;
    logic          buf_full;
    logic          buf_commit;
    logic          buf_release;

    dmaf_engine #(.MAX_PKT(MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .eot_rd(eot_rd), .eot_irq(eot_irq), .dmreq(dmreq),
        .dmack_n(dmack_n), .eot_n(eot_n), .rd_n(rd_n), .wr_n(wr_n),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .buf_addr(buf_addr),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .buf_free(buf_free), .buf_full(buf_full), .buf_commit(buf_commit),
        .buf_release(buf_release)
    );

    // buffer model
    logic [7:0]    mem [0:(1<<AW)-1];
    logic          pl_we = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [7:0]    pl_data = '0;
    logic          free_arm = 1'b0;
    logic          full_arm = 1'b0;
    int            commit_cnt;
    int            rel_cnt;

    assign buf_rdata = mem[buf_addr];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_free   <= 1'b0;
            buf_full   <= 1'b0;
            commit_cnt <= 0;
            rel_cnt    <= 0;
        end else begin
            if (buf_we) mem[buf_addr] <= buf_wdata;
            if (pl_we)  mem[pl_addr]  <= pl_data;
            if (buf_commit) begin
                commit_cnt <= commit_cnt + 1;
                buf_free   <= 1'b0;
            end else if (free_arm) buf_free <= 1'b1;
            if (buf_release) begin
                rel_cnt  <= rel_cnt + 1;
                buf_full <= 1'b0;
            end else if (full_arm) buf_full <= 1'b1;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic poke(input int a, input logic [7:0] v);
        @(negedge clk); pl_we = 1'b1; pl_addr = AW'(a); pl_data = v;
        @(negedge clk); pl_we = 1'b0;
    endtask

    task automatic arm_free();
        @(negedge clk); free_arm = 1'b1;
        @(negedge clk); free_arm = 1'b0;
    endtask

    task automatic arm_full();
        @(negedge clk); full_arm = 1'b1;
        @(negedge clk); full_arm = 1'b0;
    endtask

    task automatic clr_flag();
        @(negedge clk); eot_rd = 1'b1;
        @(negedge clk); eot_rd = 1'b0;
        #1 chk("R11 flag cleared by read", 32'(eot_irq), 32'd0);
    endtask

    task automatic wbyte(input logic [7:0] b, input logic exp_req, input string tag);
        @(negedge clk); dmack_n = 1'b0; wr_n = 1'b0; dma_wdata = b;
        #1 chk(tag, 32'(dmreq), 32'(exp_req));
        @(negedge clk); wr_n = 1'b1;
    endtask

    task automatic eot_pulse();
        @(negedge clk); dmack_n = 1'b0; eot_n = 1'b0;
        #1 chk("R9 request low during end-of-transfer", 32'(dmreq), 32'd0);
        @(negedge clk); eot_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 dmreq at reset", 32'(dmreq), 32'd0);
        chk("R1 cfg at reset", 32'(cfg_q), 32'd0);
        chk("R1 flag at reset", 32'(eot_irq), 32'd0);
        chk("R1 no buffer strobes", 32'({buf_we, buf_commit, buf_release}), 32'd0);
    endtask

    task automatic t_cfg();
        cfg_write(8'hF3);
        #1 chk("R2 readback masks bits 7..5", 32'(cfg_q), 32'h13);
        cfg_write(8'h00);
    endtask

    task automatic t_ignore();
        cfg_write(8'h0C);
        idle(3);
        #1 chk("R3 no request without free buffer", 32'(dmreq), 32'd0);
        arm_free();
        idle(1);
        #1 chk("R3 request once buffer free", 32'(dmreq), 32'd1);
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); eot_n = 1'b0;
        @(negedge clk); eot_n = 1'b1;
        #1 chk("R3 eot without ack ignored", 32'(cfg_q[2]), 32'd1);
        eot_pulse();
        idle(3);
        chk("R3 strobe without ack stored nothing (R7 empty)", 32'(commit_cnt), 32'd0);
        chk("R9 enable cleared", 32'(cfg_q[2]), 32'd0);
        chk("R11 flag set", 32'(eot_irq), 32'd1);
        dmack_n = 1'b1;
        clr_flag();
    endtask

    task automatic t_write_max();
        poke(0, 8'hEE);
        cfg_write(8'h0C);
        idle(1);
        #1 chk("R3 write request", 32'(dmreq), 32'd1);
        for (int i = 0; i < MAX; i++)
            wbyte(8'h10 + 8'(i), 1'b0, "R4 single-mode drop during strobe");
        idle(4);
        dmack_n = 1'b1;
        chk("R6 commit at max size", 32'(commit_cnt), 32'd1);
        chk("R6 header byte 0", 32'(mem[0]), 32'h00);
        chk("R6 length byte", 32'(mem[1]), 32'(MAX));
        chk("R5 first payload at offset 2", 32'(mem[2]), 32'h10);
        chk("R5 last payload", 32'(mem[MAX+1]), 32'h17);
        chk("R3 no request after commit", 32'(dmreq), 32'd0);
    endtask

    task automatic t_burst_eot();
        cfg_write(8'h0D);
        arm_free();
        idle(2);
        wbyte(8'h51, 1'b1, "R4 burst beat 0");
        wbyte(8'h52, 1'b1, "R4 burst beat 1");
        wbyte(8'h53, 1'b1, "R4 burst beat 2");
        wbyte(8'h54, 1'b0, "R4 burst final beat drop");
        #1 chk("R4 held low until strobe high seen", 32'(dmreq), 32'd0);
        @(negedge clk);
        #1 chk("R4 request back after burst", 32'(dmreq), 32'd1);
        wbyte(8'h55, 1'b1, "R4 new burst beat 0");
        eot_pulse();
        idle(4);
        dmack_n = 1'b1;
        chk("R7 early commit", 32'(commit_cnt), 32'd2);
        chk("R7 length of short packet", 32'(mem[1]), 32'd5);
        chk("R5 fifth byte", 32'(mem[6]), 32'h55);
        chk("R9 enable cleared, rest kept", 32'(cfg_q), 32'h09);
        chk("R11 flag set", 32'(eot_irq), 32'd1);
        clr_flag();
    endtask

    task automatic t_autoreload();
        cfg_write(8'h1C);
        arm_free();
        idle(2);
        wbyte(8'hA1, 1'b0, "R4 single mode");
        @(negedge clk); dmack_n = 1'b0; wr_n = 1'b0; eot_n = 1'b0; dma_wdata = 8'hA2;
        @(negedge clk); wr_n = 1'b1; eot_n = 1'b1;
        idle(4);
        chk("R7 byte with eot counted", 32'(mem[1]), 32'd2);
        chk("R7 byte with eot stored", 32'(mem[3]), 32'hA2);
        chk("R7 commit", 32'(commit_cnt), 32'd3);
        chk("R10 enable kept", 32'(cfg_q[2]), 32'd1);
        arm_free();
        idle(2);
        #1 chk("R10 re-request", 32'(dmreq), 32'd1);
        dmack_n = 1'b1;
        cfg_write(8'h00);
        clr_flag();
    endtask

    task automatic t_read();
        poke(1, 8'd3);
        poke(2, 8'hC1);
        poke(3, 8'hC2);
        poke(4, 8'hC3);
        cfg_write(8'h04);
        arm_full();
        idle(2);
        #1 chk("R3 read request", 32'(dmreq), 32'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); dmack_n = 1'b0; rd_n = 1'b0;
            #1 chk("R8 read data", 32'(dma_rdata), 32'hC1 + 32'(i));
            @(negedge clk); rd_n = 1'b1;
        end
        idle(2);
        dmack_n = 1'b1;
        chk("R8 release after last", 32'(rel_cnt), 32'd1);
        chk("R8 no request after release", 32'(dmreq), 32'd0);
        poke(1, 8'd0);
        arm_full();
        idle(4);
        chk("R8 zero length released", 32'(rel_cnt), 32'd2);
        chk("R8 zero length no request", 32'(dmreq), 32'd0);
    endtask

    task automatic t_read_eot();
        poke(1, 8'd5);
        poke(2, 8'hD0);
        arm_full();
        idle(2);
        @(negedge clk); dmack_n = 1'b0; rd_n = 1'b0;
        #1 chk("R8 read data", 32'(dma_rdata), 32'hD0);
        @(negedge clk); rd_n = 1'b1;
        eot_pulse();
        idle(3);
        dmack_n = 1'b1;
        chk("R12 eot releases packet", 32'(rel_cnt), 32'd3);
        chk("R9 enable cleared on read", 32'(cfg_q[2]), 32'd0);
        chk("R11 flag set on read", 32'(eot_irq), 32'd1);
        clr_flag();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        t_cfg();
        t_ignore();
        t_write_max();
        t_burst_eot();
        t_autoreload();
        t_read();
        t_read_eot();
        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: all requirements act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule